// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small processor core and turns six interrupt sources into one service request. Each source has a latched request flag and an enable bit. A master enable gates the whole block. Five of the sources are single requests: two external pins, two timer overflows and a serial-interface request. The sixth is a group: several peripheral requests each set a flag of their own, and when the peripheral's own enable is set they also set one shared group flag. The whole group uses one vector.

Requests may arrive at any clock cycle, but the controller only arbitrates when the instruction-phase tick input is high. At that tick it takes the highest-priority request that is both flagged and enabled. It then issues a one-cycle service strobe together with an 8-bit vector address. It clears the flag of the source it served and clears the master enable. After that it accepts nothing until the return-from-interrupt pulse arrives. The flags of the individual group peripherals are never cleared by hardware; software clears them through the register port.

Software reaches four 8-bit registers through a simple write strobe and a combinational read port. Register 0: bit 0 is the master enable, bits 1 to 3 enable ext0, ext1 and timer 0, bits 4 to 6 are the flags of ext0, ext1 and timer 0, and bit 7 reads 0. Register 1: bits 0 to 2 enable timer 1, serial and group, bits 4 to 6 are the flags of timer 1, serial and group, and the other bits read 0. Register 2 holds the per-peripheral group enables in bits GRP_N-1:0. Register 3 holds the per-peripheral group flags in the same bits.

Top module: `vic_top`

## Requirements
- R1: After reset, every register reads 0, and `svc_stb`, `svc_busy` and `svc_vec` are 0.
- R2: A write loads each implemented bit of the addressed register with the written value. Unimplemented bits read 0, so writing 0xFF reads back 0x7F from register 0, 0x77 from register 1, and 0x3F from registers 2 and 3 (with GRP_N=6).
- R3: A pulse on a source's event input sets that source's flag. A software write of 1 to a flag bit sets the flag in the same way.
- R4: A request is accepted only on a cycle where `phase_tick` is high, its flag and enable are both set, and the master enable is set. The strobe appears in the next cycle. An event that arrives in the same cycle as a tick is taken at the following tick.
- R5: When several requests are pending together, the winner in priority order is ext0, ext1, timer 0, timer 1, serial, group.
- R6: The vector for source index k (ext0=0 … group=5) is 0x04 + 4·k, so the vectors run 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18.
- R7: A grouped peripheral event always sets that peripheral's flag in register 3. It sets the shared group flag (register 1 bit 6) only when the peripheral's enable in register 2 is set. A software write of 1 to a register 3 bit behaves the same way.
- R8: On acceptance, hardware clears the served source's flag and the master enable. The group peripheral flags in register 3 stay unchanged.
- R9: `svc_busy` rises with the strobe. While it is high, no request is accepted, even if software sets the master enable again. A `rti_pulse` while busy drops `svc_busy` and sets the master enable.
- R10: `svc_stb` lasts exactly one cycle, and `svc_vec` changes only in the cycle in which `svc_stb` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_tick | input | 1 | Instruction-phase tick; arbitration happens only when it is high |
| ext0_evt | input | 1 | External interrupt 0 event pulse |
| ext1_evt | input | 1 | External interrupt 1 event pulse |
| tmr0_evt | input | 1 | Timer 0 overflow pulse |
| tmr1_evt | input | 1 | Timer 1 overflow pulse |
| ser_evt | input | 1 | Serial-interface event pulse |
| grp_evt | input | GRP_N | Grouped peripheral event pulses |
| rti_pulse | input | 1 | Return-from-interrupt pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| svc_stb | output | 1 | One-cycle service strobe |
| svc_vec | output | 8 | Vector address, held between strobes |
| svc_busy | output | 1 | Service in progress |

## Verification
The assertions watch the service outputs on every cycle. They check that the strobe is one cycle long and always follows a tick, that it never fires while service is already in progress, that busy rises with it and falls on a return pulse, that the vector stays still between strobes, and that every vector is a legal slot. Which source wins, and which flags and enables hardware clears or keeps, can only be shown by the bench's scenarios. The bench sweeps all 63 non-empty combinations of pending sources and reads the registers back. It also covers the group flag logic, an event that coincides with a tick, and a tick that arrives while service is still busy.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned NSRC = 6;
  localparam int unsigned IDXW = 3;

  typedef enum logic [IDXW-1:0] {
    SRC_EXT0 = 3'd0,
    SRC_EXT1 = 3'd1,
    SRC_TMR0 = 3'd2,
    SRC_TMR1 = 3'd3,
    SRC_SER  = 3'd4,
    SRC_GRP  = 3'd5
  } src_e;

  function automatic logic [7:0] vec_of(input logic [IDXW-1:0] idx,
                                        input logic [7:0] base,
                                        input logic [7:0] step);
    logic [7:0] k;
    k = {5'b0, idx};
    return base + step * k;
  endfunction
endpackage

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int unsigned GRP_N = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic [NSRC-2:0]   dir_evt,
  input  logic [GRP_N-1:0]  grp_evt,
  input  logic [NSRC-1:0]   clr_oh,
  input  logic              clr_gie,
  input  logic              set_gie,
  output logic [7:0]        reg_rdata,
  output logic [NSRC-1:0]   src_flag,
  output logic [NSRC-1:0]   src_en,
  output logic              gie
);
  logic [NSRC-1:0]  en_q, fl_q, en_d, fl_d;
  logic [GRP_N-1:0] gen_q, gfl_q, gen_d, gfl_d, gfl_set;
  logic             gie_d;
  logic             wr0, wr1, wr2, wr3;

  assign wr0 = reg_wr && (reg_addr == 2'd0);
  assign wr1 = reg_wr && (reg_addr == 2'd1);
  assign wr2 = reg_wr && (reg_addr == 2'd2);
  assign wr3 = reg_wr && (reg_addr == 2'd3);

  assign gfl_set = grp_evt | (wr3 ? reg_wdata[GRP_N-1:0] : '0);

  always_comb begin
    en_d  = en_q;
    fl_d  = fl_q;
    gen_d = gen_q;
    gfl_d = gfl_q;
    gie_d = gie;
    if (wr0) begin
      gie_d     = reg_wdata[0];
      en_d[2:0] = reg_wdata[3:1];
      fl_d[2:0] = reg_wdata[6:4];
    end
    if (wr1) begin
      en_d[5:3] = reg_wdata[2:0];
      fl_d[5:3] = reg_wdata[6:4];
    end
    if (wr2) gen_d = reg_wdata[GRP_N-1:0];
    if (wr3) gfl_d = reg_wdata[GRP_N-1:0];
    fl_d = fl_d & ~clr_oh;
    if (clr_gie) gie_d = 1'b0;
    if (set_gie) gie_d = 1'b1;
    gfl_d = gfl_d | gfl_set;
    fl_d[NSRC-2:0] = fl_d[NSRC-2:0] | dir_evt;
    fl_d[SRC_GRP]  = fl_d[SRC_GRP] | (|(gfl_set & gen_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      fl_q  <= '0;
      gen_q <= '0;
      gfl_q <= '0;
      gie   <= 1'b0;
    end else begin
      en_q  <= en_d;
      fl_q  <= fl_d;
      gen_q <= gen_d;
      gfl_q <= gfl_d;
      gie   <= gie_d;
    end
  end

  always_comb begin
    unique case (reg_addr)
      2'd0:    reg_rdata = {1'b0, fl_q[2:0], en_q[2:0], gie};
      2'd1:    reg_rdata = {1'b0, fl_q[5:3], 1'b0, en_q[5:3]};
      2'd2:    reg_rdata = 8'(gen_q);
      default: reg_rdata = 8'(gfl_q);
    endcase
  end

  assign src_flag = fl_q;
  assign src_en   = en_q;
endmodule

// File: rtl/vic_arb.sv
module vic_arb
  import vic_pkg::*;
(
  input  logic [NSRC-1:0] pend,
  output logic [NSRC-1:0] grant,
  output logic [IDXW-1:0] idx,
  output logic            any
);
  logic [NSRC:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < NSRC; i++) begin : g_chain
    assign grant[i]     = pend[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | pend[i];
  end

  assign any = blocked[NSRC];

  always_comb begin
    idx = '0;
    for (int i = 0; i < NSRC; i++)
      if (grant[i]) idx = IDXW'(i);
  end
endmodule

// File: rtl/vic_seq.sv
module vic_seq
  import vic_pkg::*;
#(
  parameter logic [7:0] VEC_BASE = 8'h04,
  parameter logic [7:0] VEC_STEP = 8'h04
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            phase_tick,
  input  logic            gie,
  input  logic            any,
  input  logic [IDXW-1:0] idx,
  input  logic            rti_pulse,
  output logic            accept,
  output logic            rti_ok,
  output logic            svc_stb,
  output logic [7:0]      svc_vec,
  output logic            svc_busy
);
  assign accept = phase_tick & gie & ~svc_busy & any;
  assign rti_ok = rti_pulse & svc_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_stb  <= 1'b0;
      svc_vec  <= '0;
      svc_busy <= 1'b0;
    end else begin
      svc_stb <= accept;
      if (accept) begin
        svc_vec  <= vec_of(idx, VEC_BASE, VEC_STEP);
        svc_busy <= 1'b1;
      end else if (rti_ok) begin
        svc_busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int unsigned GRP_N    = 6,
  parameter logic [7:0]  VEC_BASE = 8'h04,
  parameter logic [7:0]  VEC_STEP = 8'h04
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_tick,
  input  logic             ext0_evt,
  input  logic             ext1_evt,
  input  logic             tmr0_evt,
  input  logic             tmr1_evt,
  input  logic             ser_evt,
  input  logic [GRP_N-1:0] grp_evt,
  input  logic             rti_pulse,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             svc_stb,
  output logic [7:0]       svc_vec,
  output logic             svc_busy
);
  logic [NSRC-1:0] src_flag, src_en, pend, grant, clr_oh;
  logic [IDXW-1:0] idx;
  logic            any, gie, accept, rti_ok;

  assign pend   = src_flag & src_en;
  assign clr_oh = accept ? grant : '0;

  vic_regs #(.GRP_N(GRP_N)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .dir_evt   ({ser_evt, tmr1_evt, tmr0_evt, ext1_evt, ext0_evt}),
    .grp_evt   (grp_evt),
    .clr_oh    (clr_oh),
    .clr_gie   (accept),
    .set_gie   (rti_ok),
    .reg_rdata (reg_rdata),
    .src_flag  (src_flag),
    .src_en    (src_en),
    .gie       (gie)
  );

  vic_arb arb_i (
    .pend  (pend),
    .grant (grant),
    .idx   (idx),
    .any   (any)
  );

  vic_seq #(.VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_tick (phase_tick),
    .gie        (gie),
    .any        (any),
    .idx        (idx),
    .rti_pulse  (rti_pulse),
    .accept     (accept),
    .rti_ok     (rti_ok),
    .svc_stb    (svc_stb),
    .svc_vec    (svc_vec),
    .svc_busy   (svc_busy)
  );
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
  parameter logic [7:0] VEC_BASE = 8'h04,
  parameter logic [7:0] VEC_STEP = 8'h04
) (
  input logic       clk,
  input logic       rst_n,
  input logic       phase_tick,
  input logic       rti_pulse,
  input logic       svc_stb,
  input logic [7:0] svc_vec,
  input logic       svc_busy
);
  localparam logic [7:0] VEC_LAST = VEC_BASE + VEC_STEP * 8'd5;

  p_stb_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    svc_stb |=> !svc_stb);

  p_vec_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !svc_stb |-> $stable(svc_vec));

  p_stb_after_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    svc_stb |-> $past(phase_tick));

  p_no_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    svc_stb |-> !$past(svc_busy));

  p_busy_with_stb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    svc_stb |-> svc_busy);

  p_rti_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_busy && rti_pulse) |=> !svc_busy);

  p_vec_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    svc_stb |-> (svc_vec >= VEC_BASE && svc_vec <= VEC_LAST));
endmodule

bind vic_top vic_checker #(.VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .phase_tick (phase_tick),
  .rti_pulse  (rti_pulse),
  .svc_stb    (svc_stb),
  .svc_vec    (svc_vec),
  .svc_busy   (svc_busy)
);

// File: tb/vic_top_tb_top.sv
`timescale 1ns/1ps
module vic_top_tb_top;
  localparam int GRP_N = 6;

  logic clk = 1'b0, rst_n = 1'b0, phase_tick = 1'b0;
  logic ext0_evt = 1'b0, ext1_evt = 1'b0, tmr0_evt = 1'b0, tmr1_evt = 1'b0, ser_evt = 1'b0;
  logic [GRP_N-1:0] grp_evt = '0;
  logic rti_pulse = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata, svc_vec;
  logic svc_stb, svc_busy;
  int n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  vic_top #(.GRP_N(GRP_N)) dut_i (
    .clk(clk), .rst_n(rst_n), .phase_tick(phase_tick),
    .ext0_evt(ext0_evt), .ext1_evt(ext1_evt), .tmr0_evt(tmr0_evt),
    .tmr1_evt(tmr1_evt), .ser_evt(ser_evt), .grp_evt(grp_evt),
    .rti_pulse(rti_pulse), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .svc_stb(svc_stb), .svc_vec(svc_vec), .svc_busy(svc_busy)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic tick();
    @(negedge clk); phase_tick = 1'b1;
    @(negedge clk); phase_tick = 1'b0;
  endtask

  task automatic rti();
    @(negedge clk); rti_pulse = 1'b1;
    @(negedge clk); rti_pulse = 1'b0;
  endtask

  task automatic clean();
    wr(2'd3, 8'h00); wr(2'd2, 8'h00); wr(2'd1, 8'h00); wr(2'd0, 8'h00);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int w;
    logic [5:0] pp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) rd_chk("R1 reg", 2'(a), 8'h00);
    check("R1 stb", {7'b0, svc_stb}, 8'h00);
    check("R1 busy", {7'b0, svc_busy}, 8'h00);
    check("R1 vec", svc_vec, 8'h00);

    // R2 layout and unimplemented bits
    wr(2'd0, 8'hFF); rd_chk("R2 reg0", 2'd0, 8'h7F);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'hFF); rd_chk("R2 reg1", 2'd1, 8'h77);
    wr(2'd2, 8'hFF); rd_chk("R2 reg2", 2'd2, 8'h3F);
    wr(2'd3, 8'hFF); rd_chk("R2 reg3", 2'd3, 8'h3F);
    clean();
    rd_chk("R2 cleared", 2'd1, 8'h00);

    // R3 hardware events set flags
    @(negedge clk); ext1_evt = 1'b1; tmr1_evt = 1'b1; ser_evt = 1'b1;
    @(negedge clk); ext1_evt = 1'b0; tmr1_evt = 1'b0; ser_evt = 1'b0;
    rd_chk("R3 ext1 flag", 2'd0, 8'h20);
    rd_chk("R3 tmr1 ser flags", 2'd1, 8'h30);
    @(negedge clk); ext0_evt = 1'b1; tmr0_evt = 1'b1;
    @(negedge clk); ext0_evt = 1'b0; tmr0_evt = 1'b0;
    rd_chk("R3 ext0 tmr0 flags", 2'd0, 8'h70);
    clean();

    // R4 gating: no master enable, no source enable, no tick
    wr(2'd0, 8'h12); tick();
    check("R4 no master enable", {7'b0, svc_stb}, 8'h00);
    wr(2'd0, 8'h11); tick();
    check("R4 no source enable", {7'b0, svc_stb}, 8'h00);
    wr(2'd0, 8'h13);
    repeat (5) @(negedge clk);
    check("R4 no tick", {7'b0, svc_stb}, 8'h00);
    tick();
    check("R4 tick stb", {7'b0, svc_stb}, 8'h01);
    check("R6 ext0 vec", svc_vec, 8'h04);
    rti(); clean();

    // R4 event coinciding with tick is taken at next tick
    wr(2'd0, 8'h03);
    @(negedge clk); ext0_evt = 1'b1; phase_tick = 1'b1;
    @(negedge clk); ext0_evt = 1'b0; phase_tick = 1'b0;
    check("R4 same-cycle event not taken", {7'b0, svc_stb}, 8'h00);
    tick();
    check("R4 taken at next tick", {7'b0, svc_stb}, 8'h01);
    rti(); clean();

    // R9 busy blocks until return
    wr(2'd0, 8'h13); tick();
    check("R9 first stb", {7'b0, svc_stb}, 8'h01);
    @(negedge clk);
    check("R10 stb one cycle", {7'b0, svc_stb}, 8'h00);
    wr(2'd0, 8'h25); tick();
    check("R9 blocked while busy", {7'b0, svc_stb}, 8'h00);
    check("R10 vec held", svc_vec, 8'h04);
    check("R9 still busy", {7'b0, svc_busy}, 8'h01);
    rti();
    check("R9 busy released", {7'b0, svc_busy}, 8'h00);
    tick();
    check("R9 accepted after return", {7'b0, svc_stb}, 8'h01);
    check("R6 ext1 vec", svc_vec, 8'h08);
    rti(); clean();

    // R7 group flags, R8 group peripheral flags kept
    wr(2'd2, 8'h04); wr(2'd1, 8'h04); wr(2'd0, 8'h01);
    @(negedge clk); grp_evt = 6'b001100;
    @(negedge clk); grp_evt = '0;
    rd_chk("R7 peripheral flags", 2'd3, 8'h0C);
    rd_chk("R7 group flag", 2'd1, 8'h44);
    tick();
    check("R7 group stb", {7'b0, svc_stb}, 8'h01);
    check("R7 group vec", svc_vec, 8'h18);
    rd_chk("R8 group flag cleared", 2'd1, 8'h04);
    rd_chk("R8 peripheral flags kept", 2'd3, 8'h0C);
    rti();
    wr(2'd3, 8'h08);
    rd_chk("R7 disabled peripheral no group flag", 2'd1, 8'h04);
    wr(2'd3, 8'h00);
    wr(2'd3, 8'h04);
    rd_chk("R7 sw write sets group flag", 2'd1, 8'h44);
    clean();

    // R5 R6 R8 R9 sweep over every pending combination
    for (int p = 1; p < 64; p++) begin
      logic [5:0] pv;
      pv = 6'(p);
      w = 0;
      for (int i = 5; i >= 0; i--) if (pv[i]) w = i;
      wr(2'd1, 8'h07 | {1'b0, pv[5:3], 4'b0});
      wr(2'd0, 8'h0F | {1'b0, pv[2:0], 4'b0});
      tick();
      check("R5 sweep stb", {7'b0, svc_stb}, 8'h01);
      check("R6 sweep vec", svc_vec, 8'(4 + 4 * w));
      check("R9 sweep busy", {7'b0, svc_busy}, 8'h01);
      pp = pv & ~(6'b1 << w);
      rd_chk("R8 sweep reg0", 2'd0, {1'b0, pp[2:0], 3'b111, 1'b0});
      rd_chk("R8 sweep reg1", 2'd1, {1'b0, pp[5:3], 1'b0, 3'b111});
      rti();
      rd_chk("R9 sweep master enable restored", 2'd0, {1'b0, pp[2:0], 3'b111, 1'b1});
      wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    end

    finish_run();
  end
endmodule